// File: doc/BRIEF.md
# Windowed readout address sequencer

This block produces the order in which pixels of a 640 x 480 sensor array are read out when only a rectangular region of interest is wanted. Software sets the window's origin and size on both axes, picks the scan direction of each axis, and sets the number of idle clocks between rows. A one-clock start strobe then launches a frame. The block emits one column/row address pair per clock, together with a frame qualifier and a line qualifier.

The window settings are captured into shadow registers when a frame is launched, so the inputs may change while a frame runs. The column origin and width are kept to a granularity of 8 pixels. A window that runs past the array edge is cut back to that edge. A window with no pixels left after alignment and clipping produces no frame.

Top module: `roi_scan_top`

## Requirements
- R1: Every address output while `line_valid` is 1 lies inside the array: column below 640, row below 480.
- R2: Inside a frame, rows are emitted one after another. Each row holds every window column, one per clock, with `row_addr` constant across that row.
- R3: The three low bits of `cfg_col_start` and `cfg_width` are ignored. Origin 19 with width 21 gives the same frame as origin 16 with width 16.
- R4: With `cfg_rev_x` = 0, each row runs from the window's left column up to its right column. With `cfg_rev_x` = 1, it runs from the right column down to the left column.
- R5: With `cfg_rev_y` = 0, rows run from the window's top row down to its bottom row. With `cfg_rev_y` = 1, they run from the bottom row up to the top row.
- R6: A strobe sampled while idle is followed by one clock with `frame_valid` low. The first pixel then follows, and `frame_valid` is high from that pixel through the last pixel of the last row. `frame_valid` falls on the clock after the last pixel. `line_valid` is high only on pixel clocks.
- R7: Between two rows, `cfg_blank` clocks (sampled at the strobe) pass with `frame_valid` 1 and `line_valid` 0. A count of 0 gives back-to-back rows.
- R8: Strobes and changes of any configuration input after a frame has been launched have no effect on that frame.
- R9: Where origin plus size passes the array edge on an axis, the size is cut to end at the last column or row of the array.
- R10: If the aligned and clipped width or height is 0, for example an origin at or beyond the array edge, no frame is produced and `frame_valid` stays 0.
- R11: Both address outputs are 0 whenever `line_valid` is 0.
- R12: After reset, `frame_valid` and `line_valid` are 0 and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col_start | input | 10 | Window column origin (low 3 bits ignored) |
| cfg_row_start | input | 9 | Window row origin |
| cfg_width | input | 10 | Window width in columns (low 3 bits ignored) |
| cfg_height | input | 9 | Window height in rows |
| cfg_rev_x | input | 1 | 1: scan columns right to left |
| cfg_rev_y | input | 1 | 1: scan rows bottom to top |
| cfg_blank | input | 8 | Idle clocks inserted between rows |
| start | input | 1 | One-clock frame launch strobe |
| col_addr | output | 10 | Column address of the current pixel |
| row_addr | output | 9 | Row address of the current pixel |
| frame_valid | output | 1 | High across the frame, including blanking |
| line_valid | output | 1 | High on pixel clocks only |

## Verification
The checker assumes the configuration inputs are at known values whenever a strobe is sampled, and that the strobe is a clean single-clock pulse. The step checks use the shadowed direction flags, so they also assume the shadows change only while the block is idle. The stimulus drives every input on the falling clock edge from one task per scenario. It sets the configuration before each strobe and lowers the strobe one clock later. Configuration changes and strobes issued during a frame come only in the scenario that tests they are ignored.

// File: rtl/roi_pkg.sv
package roi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_LINE = 2'd2,
    ST_GAP  = 2'd3
  } scan_st_t;

  // Round a value down to a multiple of a power-of-two granule.
  function automatic int unsigned align_down(input int unsigned v, input int unsigned granule);
    return v - (v % granule);
  endfunction

  // Usable length of a span that starts at org and must stay below lim.
  function automatic int unsigned clip_len(input int unsigned org, input int unsigned len,
                                           input int unsigned lim);
    if (org >= lim) return 0;
    if (len > lim - org) return lim - org;
    return len;
  endfunction

  // Position of the idx-th visited element of a span, walked forward or backward.
  function automatic int unsigned map_pos(input int unsigned org, input int unsigned len,
                                          input int unsigned idx, input logic rev);
    if (rev) return org + len - 1 - idx;
    return org + idx;
  endfunction

endpackage

// File: rtl/roi_shadow.sv
module roi_shadow #(
  parameter int ARR_W = 640,
  parameter int ARR_H = 480,
  parameter int ALIGN = 8,
  parameter int CW    = 10,
  parameter int RW    = 9,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cfg_col_start,
  input  logic [RW-1:0] cfg_row_start,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  input  logic          cfg_rev_x,
  input  logic          cfg_rev_y,
  input  logic [BW-1:0] cfg_blank,
  output logic [CW-1:0] sh_x0,
  output logic [CW-1:0] sh_w,
  output logic [RW-1:0] sh_y0,
  output logic [RW-1:0] sh_h,
  output logic          sh_rx,
  output logic          sh_ry,
  output logic [BW-1:0] sh_blank,
  output logic          sh_empty
);
  import roi_pkg::*;

  logic [CW-1:0] x0_n, w_n;
  logic [RW-1:0] h_n;

  always_comb begin
    x0_n = CW'(align_down(int'(cfg_col_start), ALIGN));
    w_n  = CW'(clip_len(int'(x0_n), align_down(int'(cfg_width), ALIGN), ARR_W));
    h_n  = RW'(clip_len(int'(cfg_row_start), int'(cfg_height), ARR_H));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_x0    <= '0;
      sh_w     <= '0;
      sh_y0    <= '0;
      sh_h     <= '0;
      sh_rx    <= 1'b0;
      sh_ry    <= 1'b0;
      sh_blank <= '0;
    end else if (load) begin
      sh_x0    <= x0_n;
      sh_w     <= w_n;
      sh_y0    <= cfg_row_start;
      sh_h     <= h_n;
      sh_rx    <= cfg_rev_x;
      sh_ry    <= cfg_rev_y;
      sh_blank <= cfg_blank;
    end
  end

  assign sh_empty = (sh_w == '0) || (sh_h == '0);

endmodule

// File: rtl/roi_idx_cnt.sv
module roi_idx_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] len,
  output logic [W-1:0] idx,
  output logic         at_last
);
  assign at_last = (idx == len - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clr)     idx <= '0;
    else if (inc)     idx <= at_last ? '0 : idx + W'(1);
  end

endmodule

// File: rtl/roi_ctrl.sv
module roi_ctrl #(
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             win_empty,
  input  logic             col_last,
  input  logic             row_last,
  input  logic [BW-1:0]    blank,
  output roi_pkg::scan_st_t st,
  output logic             ev_load,
  output logic             ev_eol,
  output logic             ev_eof
);
  import roi_pkg::*;

  scan_st_t      st_n;
  logic [BW-1:0] gap_cnt;
  logic          gap_done;

  assign ev_load  = (st == ST_IDLE) && start;
  assign ev_eol   = (st == ST_LINE) && col_last && !row_last;
  assign ev_eof   = (st == ST_LINE) && col_last && row_last;
  assign gap_done = (gap_cnt == BW'(1));

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if (start) st_n = ST_ARM;
      ST_ARM:  st_n = win_empty ? ST_IDLE : ST_LINE;
      ST_LINE: begin
        if (ev_eof)                      st_n = ST_IDLE;
        else if (ev_eol && blank != '0)  st_n = ST_GAP;
      end
      ST_GAP:  if (gap_done) st_n = ST_LINE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      gap_cnt <= '0;
    end else begin
      st <= st_n;
      if (ev_eol)            gap_cnt <= blank;
      else if (st == ST_GAP) gap_cnt <= gap_cnt - BW'(1);
    end
  end

endmodule

// File: rtl/roi_scan_top.sv
module roi_scan_top #(
  parameter int ARR_W   = 640,
  parameter int ARR_H   = 480,
  parameter int ALIGN   = 8,
  parameter int BLANK_W = 8,
  parameter int CW      = $clog2(ARR_W + 1),
  parameter int RW      = $clog2(ARR_H + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      cfg_col_start,
  input  logic [RW-1:0]      cfg_row_start,
  input  logic [CW-1:0]      cfg_width,
  input  logic [RW-1:0]      cfg_height,
  input  logic               cfg_rev_x,
  input  logic               cfg_rev_y,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic               start,
  output logic [CW-1:0]      col_addr,
  output logic [RW-1:0]      row_addr,
  output logic               frame_valid,
  output logic               line_valid
);
  import roi_pkg::*;

  scan_st_t            st;
  logic                ev_load, ev_eol, ev_eof;
  logic [CW-1:0]       sh_x0, sh_w, col_idx;
  logic [RW-1:0]       sh_y0, sh_h, row_idx;
  logic                sh_rx, sh_ry, sh_empty;
  logic [BLANK_W-1:0]  sh_blank;
  logic                col_last, row_last;
  logic                pix_cyc;

  roi_shadow #(
    .ARR_W(ARR_W), .ARR_H(ARR_H), .ALIGN(ALIGN), .CW(CW), .RW(RW), .BW(BLANK_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(ev_load),
    .cfg_col_start(cfg_col_start), .cfg_row_start(cfg_row_start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_rev_x(cfg_rev_x), .cfg_rev_y(cfg_rev_y), .cfg_blank(cfg_blank),
    .sh_x0(sh_x0), .sh_w(sh_w), .sh_y0(sh_y0), .sh_h(sh_h),
    .sh_rx(sh_rx), .sh_ry(sh_ry), .sh_blank(sh_blank), .sh_empty(sh_empty)
  );

  roi_ctrl #(.BW(BLANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .win_empty(sh_empty),
    .col_last(col_last), .row_last(row_last), .blank(sh_blank),
    .st(st), .ev_load(ev_load), .ev_eol(ev_eol), .ev_eof(ev_eof)
  );

  assign pix_cyc = (st == ST_LINE);

  roi_idx_cnt #(.W(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(ev_load), .inc(pix_cyc),
    .len(sh_w), .idx(col_idx), .at_last(col_last)
  );

  roi_idx_cnt #(.W(RW)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(ev_load), .inc(ev_eol),
    .len(sh_h), .idx(row_idx), .at_last(row_last)
  );

  assign line_valid  = pix_cyc;
  assign frame_valid = (st == ST_LINE) || (st == ST_GAP);
  assign col_addr    = pix_cyc ? CW'(map_pos(int'(sh_x0), int'(sh_w), int'(col_idx), sh_rx)) : '0;
  assign row_addr    = pix_cyc ? RW'(map_pos(int'(sh_y0), int'(sh_h), int'(row_idx), sh_ry)) : '0;

endmodule

// File: rtl/roi_scan_chk.sv
module roi_scan_chk #(
  parameter int ARR_W   = 640,
  parameter int ARR_H   = 480,
  parameter int BLANK_W = 8,
  parameter int CW      = 10,
  parameter int RW      = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      col_addr,
  input logic [RW-1:0]      row_addr,
  input logic               frame_valid,
  input logic               line_valid,
  input logic               ev_load,
  input logic               ev_eol,
  input logic               ev_eof,
  input logic               sh_rx,
  input logic [CW-1:0]      sh_x0,
  input logic [CW-1:0]      sh_w,
  input logic [RW-1:0]      sh_y0,
  input logic [RW-1:0]      sh_h,
  input logic [BLANK_W-1:0] sh_blank
);

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (int'(col_addr) < ARR_W) && (int'(row_addr) < ARR_H)); // R1

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && $past(line_valid) && !$past(ev_eol) |-> $stable(row_addr)); // R2

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && $past(line_valid) && !$past(ev_eol) |->
      col_addr == (sh_rx ? $past(col_addr) - CW'(1) : $past(col_addr) + CW'(1))); // R4

  AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid); // R6

  AST_FV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eof |=> !frame_valid); // R6

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $stable({sh_x0, sh_w, sh_y0, sh_h, sh_rx, sh_blank})); // R8

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |-> !frame_valid); // R8

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> (col_addr == '0) && (row_addr == '0)); // R11

endmodule

bind roi_scan_top roi_scan_chk #(
  .ARR_W(ARR_W), .ARR_H(ARR_H), .BLANK_W(BLANK_W), .CW(CW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .col_addr(col_addr), .row_addr(row_addr),
  .frame_valid(frame_valid), .line_valid(line_valid),
  .ev_load(ev_load), .ev_eol(ev_eol), .ev_eof(ev_eof), .sh_rx(sh_rx),
  .sh_x0(sh_x0), .sh_w(sh_w), .sh_y0(sh_y0), .sh_h(sh_h), .sh_blank(sh_blank)
);

// File: tb/sim_roi_scan_top.sv
module sim_roi_scan_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfg_col_start = '0, cfg_width = '0;
  logic [8:0] cfg_row_start = '0, cfg_height = '0;
  logic       cfg_rev_x = 1'b0, cfg_rev_y = 1'b0;
  logic [7:0] cfg_blank = '0;
  logic       start = 1'b0;
  logic [9:0] col_addr;
  logic [8:0] row_addr;
  logic       frame_valid, line_valid;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  roi_scan_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_col_start(cfg_col_start), .cfg_row_start(cfg_row_start),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_rev_x(cfg_rev_x),
    .cfg_rev_y(cfg_rev_y), .cfg_blank(cfg_blank), .start(start),
    .col_addr(col_addr), .row_addr(row_addr), .frame_valid(frame_valid), .line_valid(line_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=<100000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int span(input int org, input int len, input int lim);
    int e;
    if (org >= lim) return 0;
    e = org + len;
    if (e > lim) e = lim;
    return e - org;
  endfunction

  function automatic int pack(input bit fv, input bit lv, input int c, input int r);
    return (int'(fv) << 21) | (int'(lv) << 20) | (c << 10) | r;
  endfunction

  function automatic int obs();
    return pack(frame_valid, line_valid, int'(col_addr), int'(row_addr));
  endfunction

  task automatic run_frame(input string req, input int x, input int y, input int w, input int h,
                           input bit rx, input bit ry, input int bl, input bit disturb);
    int ex, ew, eh, n, errs, fa, fe, exp_v;
    ex = (x / 8) * 8;
    ew = span(ex, (w / 8) * 8, 640);
    eh = span(y, h, 480);
    cfg_col_start = 10'(x); cfg_row_start = 9'(y);
    cfg_width = 10'(w); cfg_height = 9'(h);
    cfg_rev_x = rx; cfg_rev_y = ry; cfg_blank = 8'(bl);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!frame_valid && !line_valid, "R6", {req, " gap after strobe"}, obs(), 0);
    if (ew == 0 || eh == 0) begin
      errs = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (frame_valid || line_valid) errs++;
      end
      check(errs == 0, "R10", {req, " empty window gives no frame"}, errs, 0);
      return;
    end
    @(negedge clk);
    n = 0; errs = 0; fa = 0; fe = 0;
    for (int r = 0; r < eh; r++) begin
      for (int c = 0; c < ew; c++) begin
        exp_v = pack(1'b1, 1'b1, rx ? ex + ew - 1 - c : ex + c, ry ? y + eh - 1 - r : y + r);
        if (obs() != exp_v) begin
          if (errs == 0) begin fa = obs(); fe = exp_v; end
          errs++;
        end
        if (disturb && n == 2) begin
          cfg_col_start = 10'd0; cfg_row_start = 9'd0; cfg_width = 10'd64;
          cfg_height = 9'd9; cfg_rev_x = ~rx; cfg_rev_y = ~ry; cfg_blank = 8'd0;
          start = 1'b1;
        end
        n++;
        @(negedge clk);
        start = 1'b0;
      end
      if (r != eh - 1) begin
        for (int b = 0; b < bl; b++) begin
          if (obs() != pack(1'b1, 1'b0, 0, 0)) begin
            if (errs == 0) begin fa = obs(); fe = pack(1'b1, 1'b0, 0, 0); end
            errs++;
          end
          @(negedge clk);
        end
      end
    end
    check(errs == 0, req, "pixel stream {fv,lv,col,row}", fa, fe);
    check(!frame_valid && !line_valid, "R6", {req, " frame end"}, obs(), 0);
  endtask

  task automatic t_reset();
    check(!frame_valid && !line_valid && col_addr == 0 && row_addr == 0,
          "R12", "state after reset", obs(), 0);
  endtask

  task automatic t_basic();   run_frame("R2 R6 R7 forward",       16, 8, 24, 3, 0, 0, 2, 0); endtask
  task automatic t_rev_x();   run_frame("R4 columns reversed",    40, 100, 16, 2, 1, 0, 1, 0); endtask
  task automatic t_rev_y();   run_frame("R5 rows reversed",       8, 20, 8, 4, 0, 1, 3, 0); endtask
  task automatic t_no_gap();  run_frame("R7 zero blanking",       0, 0, 16, 3, 1, 1, 0, 0); endtask
  task automatic t_align();   run_frame("R3 alignment",           19, 5, 21, 2, 0, 0, 1, 0); endtask
  task automatic t_clip();    run_frame("R9 R1 clip to edge",     632, 478, 64, 10, 0, 0, 1, 0); endtask
  task automatic t_clip_rev(); run_frame("R9 R1 clip reversed",   630, 470, 40, 20, 1, 1, 0, 0); endtask
  task automatic t_narrow();  run_frame("R10 width below granule", 8, 8, 5, 4, 0, 0, 1, 0); endtask
  task automatic t_offedge(); run_frame("R10 row origin off array", 8, 480, 16, 4, 0, 0, 1, 0); endtask
  task automatic t_disturb(); run_frame("R8 mid-frame changes",   24, 30, 16, 3, 0, 0, 2, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rev_x();
    t_rev_y();
    t_no_gap();
    t_align();
    t_clip();
    t_clip_rev();
    t_narrow();
    t_offedge();
    t_disturb();
    t_basic();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule